// File: doc/BRIEF.md
# Odd-Integer Sieve Candidate Generator

This block walks the odd integers upward from 3 and tests one value on each active clock. The test runs against a fixed set of small odd primes in parallel. The set holds the first `NUM_FACTORS` odd primes and is computed when the design is elaborated. Each prime has its own wrapping counter, and that counter reaches zero exactly on the odd multiples of its prime. A value that no counter flags is a candidate prime, and the block offers it on a valid/ready output.

Values are sent as gaps, not as absolute numbers. Each word is half the difference between the value and the previously emitted candidate, so it fits a narrow field in an external buffer. A second output marks a candidate as a proven prime when it lies below the square of the smallest odd prime that has no counter.

Generation pauses, with all state held, while the buffer reports full or the enable is low. It stops for good once the current value passes `MAX_VAL`.

Top module: `sieve_gen`

## Requirements
- R1: The values tested are 3, 5, 7, ... in order, each odd value tested exactly once. The emitted candidates therefore form a strictly increasing odd sequence, and none is skipped.
- R2: A value is never emitted if it is an odd multiple of a checked prime, other than that prime itself. With the defaults the checked primes are 3, 5, 7 and 11.
- R3: Each checked prime is itself emitted. With the defaults the stream starts 3, 5, 7, 11, 13, 17, 19, 23, 29, 31, 37, 41, 43, 47, 53, 59.
- R4: `out_prime` is 1 exactly when the emitted value is below the square of the first unchecked odd prime (169 with the defaults). Every value flagged this way is a true prime.
- R5: `out_delta` equals (value − previous emitted value) / 2. For the first word after reset the previous value is taken as 1, so the first word is 1. `out_delta` is never 0 while valid.
- R6: While `buf_full` is 1, `out_valid` is 0 and the current value and all counters hold. After `buf_full` falls, generation continues from the same value.
- R7: While `out_valid` is 1 and `out_ready` is 0 (with enable high and buffer not full), the same word stays on the output and the value does not advance.
- R8: While `enable` is 0, `out_valid` is 0 and no state changes.
- R9: Once the current value exceeds `MAX_VAL`, `gen_done` is 1 and stays 1 until reset, and `out_valid` is 0.
- R10: After reset, `gen_done` is 0, `out_valid` is 0 while `enable` is 0, and the first word offered is delta 1 with `out_prime` 1 (the value 3).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Run permission; low pauses generation |
| buf_full | input | 1 | Destination buffer full; halts generation and holds state |
| out_ready | input | 1 | Consumer accepts the offered word |
| out_valid | output | 1 | A candidate word is offered |
| out_delta | output | DELTA_W | Half the gap to the previous emitted candidate |
| out_prime | output | 1 | Candidate lies below the proven-prime threshold |
| gen_done | output | 1 | Value range exhausted |

## Verification
The assertions assume that `out_ready` and `buf_full` may change in any cycle. They also assume that a word withdrawn because the buffer filled or the enable fell is offered again unchanged later. The stream checks therefore count only words where valid and ready are both high.

The stimulus toggles `enable`, `buf_full` and `out_ready` on co-prime periods, so every stall mixes with both candidate and rejected values. It also walks the whole range up to `MAX_VAL`, so the threshold crossing at 169 and the large prime gaps near the top of the range are both exercised.

// File: rtl/sieve_pkg.sv
package sieve_pkg;

   // Returns the odd prime at position idx (0 -> 3, 1 -> 5, ...).
   function automatic int odd_prime(input int idx);
      int cnt;
      int found;
      bit is_p;
      cnt   = 0;
      found = 0;
      for (int v = 3; v < 8192; v += 2) begin
         is_p = 1'b1;
         for (int d = 3; d * d <= v; d += 2)
            if (v % d == 0) is_p = 1'b0;
         if (is_p && found == 0) begin
            if (cnt == idx) found = v;
            cnt++;
         end
      end
      return found;
   endfunction

endpackage

// File: rtl/sieve_factor_cell.sv
// One divisibility checker: a modulo-FACTOR counter advanced once per
// tested odd value. Its zero lines up with odd multiples of FACTOR.
module sieve_factor_cell #(
   parameter int FACTOR = 3
) (
   input  logic clk,
   input  logic rst,
   input  logic step,
   output logic hit
);
   localparam int CW   = $clog2(FACTOR);
   // Step index at which the tested value equals FACTOR (value = 3 + 2k).
   localparam int K0   = (FACTOR - 3) / 2;
   localparam logic [CW-1:0] INIT = CW'((FACTOR - K0) % FACTOR);
   localparam logic [CW-1:0] TOP  = CW'(FACTOR - 1);

   logic [CW-1:0] cnt;
   logic          armed;   // first zero (the prime itself) already passed
   logic          zero;

   assign zero = (cnt == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt   <= INIT;
         armed <= 1'b0;
      end else if (step) begin
         cnt <= (cnt == TOP) ? '0 : cnt + 1'b1;
         if (zero) armed <= 1'b1;
      end
   end

   assign hit = zero & armed;

endmodule

// File: rtl/sieve_delta_enc.sv
// Holds the last emitted value and forms the half-gap word.
module sieve_delta_enc #(
   parameter int VAL_W   = 16,
   parameter int DELTA_W = 16
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               take,
   input  logic [VAL_W-1:0]   cur,
   output logic [DELTA_W-1:0] delta
);
   logic [VAL_W-1:0] last;
   logic [VAL_W-1:0] diff;

   always_ff @(posedge clk) begin
      if (rst)       last <= VAL_W'(1);
      else if (take) last <= cur;
   end

   assign diff  = cur - last;
   assign delta = DELTA_W'(diff[VAL_W-1:1]);

endmodule

// File: rtl/sieve_gen.sv
module sieve_gen #(
   parameter int NUM_FACTORS = 4,
   parameter int VAL_W       = 16,
   parameter int DELTA_W     = 16,
   parameter int MAX_VAL     = 4095
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               enable,
   input  logic               buf_full,
   input  logic               out_ready,
   output logic               out_valid,
   output logic [DELTA_W-1:0] out_delta,
   output logic               out_prime,
   output logic               gen_done
);
   localparam int NEXT_P = sieve_pkg::odd_prime(NUM_FACTORS);
   localparam int THRESH = NEXT_P * NEXT_P;

   // Elaboration-time parameter checks.
   if (NUM_FACTORS < 1 || NUM_FACTORS > 32) begin : g_bad_nf
      $error("sieve_gen: NUM_FACTORS out of range");
   end
   if (VAL_W > 30 || MAX_VAL + 2 >= (1 << VAL_W)) begin : g_bad_vw
      $error("sieve_gen: VAL_W cannot hold MAX_VAL");
   end
   if (DELTA_W < 2 || DELTA_W > VAL_W) begin : g_bad_dw
      $error("sieve_gen: DELTA_W out of range");
   end

   logic [VAL_W-1:0]       cur;
   logic [NUM_FACTORS-1:0] hits;
   logic                   active;
   logic                   cand;
   logic                   advance;

   for (genvar g = 0; g < NUM_FACTORS; g++) begin : g_fac
      sieve_factor_cell #(
         .FACTOR (sieve_pkg::odd_prime(g))
      ) u_cell (
         .clk  (clk),
         .rst  (rst),
         .step (advance),
         .hit  (hits[g])
      );
   end

   assign gen_done  = (int'(cur) > MAX_VAL);
   assign active    = enable & ~buf_full & ~gen_done;
   assign cand      = ~|hits;
   assign out_valid = active & cand;
   assign advance   = active & (~cand | out_ready);
   assign out_prime = (int'(cur) < THRESH);

   always_ff @(posedge clk) begin
      if (rst)          cur <= VAL_W'(3);
      else if (advance) cur <= cur + VAL_W'(2);
   end

   sieve_delta_enc #(
      .VAL_W   (VAL_W),
      .DELTA_W (DELTA_W)
   ) u_delta (
      .clk   (clk),
      .rst   (rst),
      .take  (out_valid & out_ready),
      .cur   (cur),
      .delta (out_delta)
   );

endmodule

// File: rtl/sieve_gen_chk.sv
module sieve_gen_chk #(
   parameter int VAL_W   = 16,
   parameter int DELTA_W = 16
) (
   input logic               clk,
   input logic               rst,
   input logic               enable,
   input logic               buf_full,
   input logic               out_ready,
   input logic               out_valid,
   input logic [DELTA_W-1:0] out_delta,
   input logic               gen_done,
   input logic [VAL_W-1:0]   cur
);
   p_odd_value_r1: assert property (@(posedge clk) disable iff (rst)
      cur[0] == 1'b1);

   p_step_by_two_r1: assert property (@(posedge clk) disable iff (rst)
      (cur != $past(cur)) |-> (cur == $past(cur) + VAL_W'(2)));

   p_delta_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_delta != '0));

   p_full_blocks_r6: assert property (@(posedge clk) disable iff (rst)
      buf_full |-> !out_valid);

   p_full_holds_r6: assert property (@(posedge clk) disable iff (rst)
      buf_full |=> $stable(cur));

   p_hold_word_r7: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> (!out_valid || $stable(out_delta)));

   p_enable_gate_r8: assert property (@(posedge clk) disable iff (rst)
      !enable |-> !out_valid);

   p_enable_holds_r8: assert property (@(posedge clk) disable iff (rst)
      !enable |=> $stable(cur));

   p_done_sticky_r9: assert property (@(posedge clk) disable iff (rst)
      gen_done |=> gen_done);

   p_done_quiet_r9: assert property (@(posedge clk) disable iff (rst)
      gen_done |-> !out_valid);

endmodule

bind sieve_gen sieve_gen_chk #(
   .VAL_W   (VAL_W),
   .DELTA_W (DELTA_W)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .enable    (enable),
   .buf_full  (buf_full),
   .out_ready (out_ready),
   .out_valid (out_valid),
   .out_delta (out_delta),
   .gen_done  (gen_done),
   .cur       (cur)
);

// File: tb/sieve_gen_test.sv
`timescale 1ns/1ps
module sieve_gen_test;
   localparam int MAXV = 4095;
   localparam int THR  = 169;
   localparam int EXP_HEAD [16] = '{3, 5, 7, 11, 13, 17, 19, 23,
                                    29, 31, 37, 41, 43, 47, 53, 59};

   logic        clk = 1'b0;
   logic        rst, enable, buf_full, out_ready;
   logic        out_valid, out_prime, gen_done;
   logic [15:0] out_delta;

   int checks = 0;
   int errors = 0;
   int n_out  = 0;
   int acc    = 1;   // reconstructed value
   int ref_v  = 1;   // reference previous candidate

   always #2.5 clk = ~clk;

   sieve_gen uut (
      .clk(clk), .rst(rst), .enable(enable), .buf_full(buf_full),
      .out_ready(out_ready), .out_valid(out_valid), .out_delta(out_delta),
      .out_prime(out_prime), .gen_done(gen_done)
   );

   function automatic bit is_cand(input int v);
      int f [4] = '{3, 5, 7, 11};
      bit ok = 1'b1;
      foreach (f[i]) if (v % f[i] == 0 && v != f[i]) ok = 1'b0;
      return ok;
   endfunction

   function automatic bit is_prime(input int v);
      bit ok = (v >= 2);
      for (int d = 2; d * d <= v; d++) if (v % d == 0) ok = 1'b0;
      return ok;
   endfunction

   function automatic int next_cand(input int p);
      int r = 0;
      for (int v = p + 2; v < 100000 && r == 0; v += 2)
         if (is_cand(v)) r = v;
      return r;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   // Stream monitor: every accepted word against the reference.
   always @(negedge clk) begin
      if (!rst && out_valid && out_ready) begin
         int nv;
         nv = next_cand(ref_v);
         acc = acc + 2 * int'(out_delta);
         check(int'(out_delta) == (nv - ref_v) / 2, "R5 delta", int'(out_delta), (nv - ref_v) / 2);
         check(acc == nv, "R1/R2 value", acc, nv);
         check(out_prime == (nv < THR), "R4 flag", out_prime, nv < THR);
         if (out_prime) check(is_prime(acc), "R4 true prime", acc, 1);
         if (n_out < 16) check(acc == EXP_HEAD[n_out], "R3 head", acc, EXP_HEAD[n_out]);
         ref_v = nv;
         n_out++;
      end
   end

   task automatic cyc();
      @(posedge clk); #1;
   endtask

   initial begin
      int total;
      int held;
      int cnt;
      rst = 1'b1; enable = 1'b0; buf_full = 1'b0; out_ready = 1'b1;
      repeat (3) cyc();
      rst = 1'b0;
      cyc();
      @(negedge clk);
      check(out_valid == 1'b0, "R10 idle valid", out_valid, 0);
      check(gen_done == 1'b0, "R10 done", gen_done, 0);
      // R8: enable low keeps output quiet
      repeat (3) begin cyc(); @(negedge clk); check(!out_valid, "R8 disabled", out_valid, 0); end
      // R10: first word offered
      out_ready = 1'b0; enable = 1'b1;
      #1; @(negedge clk);
      check(out_valid && out_delta == 16'd1 && out_prime, "R10 first word", out_delta, 1);
      // R7: holds while not ready
      held = out_delta;
      repeat (3) begin
         cyc(); @(negedge clk);
         check(out_valid && int'(out_delta) == held, "R7 hold", out_delta, held);
      end
      out_ready = 1'b1;
      repeat (10) cyc();
      // R6: buffer full halts
      buf_full = 1'b1;
      repeat (4) begin
         cyc(); @(negedge clk);
         check(!out_valid, "R6 full", out_valid, 0);
      end
      buf_full = 1'b0;
      // R6/R8 mixed pattern through full range
      cnt = 0;
      while (!gen_done && cnt < 100000) begin
         cyc();
         enable    = (cnt % 29) != 11;
         buf_full  = (cnt % 13) == 5;
         out_ready = (cnt % 7) != 3;
         cnt++;
      end
      if (cnt >= 100000) check(1'b0, "watchdog", cnt, 0);
      enable = 1'b1; buf_full = 1'b0; out_ready = 1'b1;
      repeat (3) cyc();
      @(negedge clk);
      total = 0;
      for (int v = 3; v <= MAXV; v += 2) if (is_cand(v)) total++;
      check(n_out == total, "R1 count", n_out, total);
      check(gen_done == 1'b1, "R9 done", gen_done, 1);
      check(out_valid == 1'b0, "R9 quiet", out_valid, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule